// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Memory/I-O Decoder

This block connects a processor-style bus, whose low address byte shares eight lines with data, to a small system made of a ROM, a RAM and I/O ports. During the address phase the latch strobe is high. While it is high, the block captures the shared low byte and the twelve dedicated upper lines. It then presents a steady 20-bit address for the rest of the cycle, while the shared lines carry data.

The block combines the active-low read and write strobes with the memory-or-I/O status line. From them it forms four separate active-low commands: memory read, memory write, I/O read and I/O write. It decodes the latched address into active-low selects for an 8 KB ROM at FE000h and an 8 KB RAM at 00000h. It also passes the transfer direction to the external data buffer and enables that buffer only while a strobe is active.

A mode input switches between full decoding and partial decoding. Partial decoding looks only at address bit 13, so each region repeats across the address space.

Top module: `mux_bus_bridge`

## Requirements
- R1: When `ale` is high at a rising clock edge, `addr_out` becomes `{a_hi, ad_in}` after that edge. While `ale` is low, `addr_out` holds its value whatever `ad_in` and `a_hi` do.
- R2: While `rst_n` is low, `addr_out` is 0. While `rd_n` and `wr_n` are both high, all four command strobes, both chip selects and `buf_en_n` are high.
- R3: `mem_rd_n` is low exactly when `rd_n` is low and `io_m` is 0, and `mem_wr_n` is low exactly when `wr_n` is low and `io_m` is 0. The value `io_m` = 0 means a memory cycle.
- R4: `io_rd_n` is low exactly when `rd_n` is low and `io_m` is 1, and `io_wr_n` is low exactly when `wr_n` is low and `io_m` is 1.
- R5: With `partial_mode` = 0, `rom_cs_n` is low exactly when a memory cycle has `rd_n` or `wr_n` low and `addr_out[19:13]` is all ones (FE000h to FFFFFh).
- R6: With `partial_mode` = 0, `ram_cs_n` is low exactly when a memory cycle has `rd_n` or `wr_n` low and `addr_out[19:13]` is all zeros (00000h to 01FFFh). Any other address asserts neither select.
- R7: With `partial_mode` = 1, only `addr_out[13]` decides the region: 1 selects ROM and 0 selects RAM, under the same memory-cycle and strobe condition.
- R8: `buf_dir` equals `dt_r` at all times. A value of 1 means the processor drives data out, and 0 means data flows toward the processor.
- R9: `buf_en_n` is low exactly when `rd_n` or `wr_n` is low, so the buffer stays off during the address phase.
- R10: At most one chip select is low at a time, and an I/O cycle (`io_m` = 1) asserts no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| partial_mode | input | 1 | 1 = decode the region from bit 13 only |
| ale | input | 1 | Address latch strobe, active high |
| ad_in | input | 8 | Shared address/data lines, low byte |
| a_hi | input | 12 | Dedicated address lines 19..8 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_m | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| dt_r | input | 1 | Transfer direction: 1 = processor transmits |
| addr_out | output | 20 | Latched address |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| buf_dir | output | 1 | Data buffer direction |
| buf_en_n | output | 1 | Data buffer enable, active low |

## Verification
The only stored state is the latched address. A wrong capture, or a failure to hold it, shows up in `addr_out` in the first data-phase sample after the latch pulse. It then corrupts the chip selects in that same cycle. The bench changes the shared lines between the address and data phases, so a latch that stays transparent is caught there. All other outputs are combinational. A wrong decode appears in the same cycle as the strobe that exposes it, and the bench checks every output in both the active phase and the idle phase of each transfer.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_RAM  = 2'd2
  } region_e;

  // Strobe lane index: bit 0 = write, bit 1 = I/O.
  localparam int LANE_MEM_RD = 0;
  localparam int LANE_MEM_WR = 1;
  localparam int LANE_IO_RD  = 2;
  localparam int LANE_IO_WR  = 3;
  localparam int LANES       = 4;

  // Full decode: all-ones tag is ROM, all-zeros tag is RAM.
  function automatic region_e full_region(input logic all_one, input logic all_zero);
    if (all_one)       return RGN_ROM;
    else if (all_zero) return RGN_RAM;
    else               return RGN_NONE;
  endfunction

  // Partial decode: a single address line picks the region.
  function automatic region_e partial_region(input logic pick_bit);
    return pick_bit ? RGN_ROM : RGN_RAM;
  endfunction
endpackage

// File: rtl/mbb_addr_latch.sv
module mbb_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 12,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   lo_bus,
  input  logic [HI_W-1:0]   hi_bus,
  output logic [ADDR_W-1:0] addr_q
);
  logic              capture_evt;
  logic [ADDR_W-1:0] addr_next;

  assign capture_evt = ale;
  assign addr_next   = {hi_bus, lo_bus};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= '0;
    else if (capture_evt) addr_q <= addr_next;
  end

  // R1: the value on the lines is captured during the latch pulse
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (addr_q == $past({hi_bus, lo_bus})));
  // R1: without a pulse the address holds while the lines carry data
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(addr_q));
endmodule

// File: rtl/mbb_cmd_decode.sv
module mbb_cmd_decode
  import mbb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             io_m,
  output logic [LANES-1:0] strobe_n,
  output logic             any_strobe
);
  // OR-type gating in active-low logic, one lane per command.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic dir_n;
    logic space_n;
    if ((i % 2) == 1) begin : g_wr
      assign dir_n = wr_n;
    end else begin : g_rd
      assign dir_n = rd_n;
    end
    if (i >= 2) begin : g_io
      assign space_n = ~io_m;
    end else begin : g_mem
      assign space_n = io_m;
    end
    assign strobe_n[i] = dir_n | space_n;
  end

  assign any_strobe = ~rd_n | ~wr_n;

  // R3: a memory command and an I/O command never overlap
  p_rd_space_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!strobe_n[LANE_MEM_RD] && !strobe_n[LANE_IO_RD]));
  // R4: an I/O write needs the I/O status level
  p_io_wr_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n[LANE_IO_WR] |-> (io_m && !wr_n));
  // R2: with both strobes idle no command lane is active
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> (strobe_n == '1));
endmodule

// File: rtl/mbb_region_decode.sv
module mbb_region_decode
  import mbb_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int REGION_BITS = 13,
  localparam int TAG_W      = ADDR_W - REGION_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              partial_mode,
  output region_e           rgn
);
  logic [TAG_W-1:0] tag;
  logic             tag_ones;
  logic             tag_zeros;
  logic             pick_bit;
  region_e          rgn_full;
  region_e          rgn_part;

  assign tag       = addr[ADDR_W-1:REGION_BITS];
  assign tag_ones  = &tag;
  assign tag_zeros = ~|tag;
  assign pick_bit  = addr[REGION_BITS];
  assign rgn_full  = full_region(tag_ones, tag_zeros);
  assign rgn_part  = partial_region(pick_bit);
  assign rgn       = partial_mode ? rgn_part : rgn_full;
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
  import mbb_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_W        = 12,
  parameter int REGION_BITS = 13,
  localparam int ADDR_W     = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              partial_mode,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   a_hi,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              io_m,
  input  logic              dt_r,
  output logic [ADDR_W-1:0] addr_out,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              buf_dir,
  output logic              buf_en_n
);
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  strobe_n;
  logic              any_strobe;
  logic              mem_active;
  region_e           rgn;

  mbb_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale),
    .lo_bus(ad_in), .hi_bus(a_hi), .addr_q(addr_q)
  );

  mbb_cmd_decode u_cmd (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .strobe_n(strobe_n), .any_strobe(any_strobe)
  );

  mbb_region_decode #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_rgn (
    .addr(addr_q), .partial_mode(partial_mode), .rgn(rgn)
  );

  assign mem_active = any_strobe & ~io_m;

  assign addr_out = addr_q;
  assign mem_rd_n = strobe_n[LANE_MEM_RD];
  assign mem_wr_n = strobe_n[LANE_MEM_WR];
  assign io_rd_n  = strobe_n[LANE_IO_RD];
  assign io_wr_n  = strobe_n[LANE_IO_WR];
  assign rom_cs_n = ~(mem_active && (rgn == RGN_ROM));
  assign ram_cs_n = ~(mem_active && (rgn == RGN_RAM));
  assign buf_dir  = dt_r;
  assign buf_en_n = ~any_strobe;

  // R10: the two chip selects are never low together
  p_cs_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));
  // R10: an I/O cycle selects no memory device
  p_io_no_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (rom_cs_n && ram_cs_n));
  // R9: the buffer stays off while both strobes are idle
  p_buf_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> buf_en_n);
  // R5: a ROM select in full mode implies the top address bits are all high
  p_rom_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && !partial_mode) |-> (&addr_out[ADDR_W-1:REGION_BITS]));
  // R3: a chip select only appears with a memory command
  p_cs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n || !ram_cs_n) |-> (!mem_rd_n || !mem_wr_n));
endmodule

// File: tb/tb_mux_bus_bridge.sv
`timescale 1ns/1ps
module tb_mux_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        partial_mode = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  ad_in = '0;
  logic [11:0] a_hi = '0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        io_m = 1'b0;
  logic        dt_r = 1'b0;
  logic [19:0] addr_out;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic        rom_cs_n, ram_cs_n, buf_dir, buf_en_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_bridge dut (
    .clk(clk), .rst_n(rst_n), .partial_mode(partial_mode), .ale(ale),
    .ad_in(ad_in), .a_hi(a_hi), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .dt_r(dt_r), .addr_out(addr_out), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .buf_dir(buf_dir),
    .buf_en_n(buf_en_n)
  );

  // sel: 0 = none, 1 = ROM, 2 = RAM
  typedef struct packed {
    logic [19:0] a;
    logic        part;
    logic        io;
    logic        wr;
    logic [1:0]  sel;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{20'hFE000, 1'b0, 1'b0, 1'b0, 2'd1},
    '{20'hFFFFF, 1'b0, 1'b0, 1'b1, 2'd1},
    '{20'h00000, 1'b0, 1'b0, 1'b0, 2'd2},
    '{20'h01FFF, 1'b0, 1'b0, 1'b1, 2'd2},
    '{20'h02000, 1'b0, 1'b0, 1'b0, 2'd0},
    '{20'h80123, 1'b0, 1'b0, 1'b1, 2'd0},
    '{20'h0A345, 1'b1, 1'b0, 1'b0, 2'd1},
    '{20'h51234, 1'b1, 1'b0, 1'b1, 2'd2},
    '{20'h7C000, 1'b1, 1'b0, 1'b0, 2'd2},
    '{20'hFE000, 1'b0, 1'b1, 1'b0, 2'd0},
    '{20'h00042, 1'b1, 1'b1, 1'b1, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string ctx);
    chk({ctx, " R2 commands idle"}, {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
    chk({ctx, " R2 selects idle"}, {rom_cs_n, ram_cs_n}, 2'b11);
    chk({ctx, " R9 buffer off"}, buf_en_n, 1'b1);
  endtask

  // One transfer: latch pulse, data phase with a strobe, idle phase.
  task automatic transfer(input vec_t v);
    logic [19:0] held;
    @(negedge clk);
    partial_mode = v.part;
    ad_in = v.a[7:0];
    a_hi  = v.a[19:8];
    io_m  = v.io;
    dt_r  = 1'b0;
    ale   = 1'b1;
    #1;
    check_idle("address phase");
    @(negedge clk);
    ale   = 1'b0;
    ad_in = ~v.a[7:0];
    a_hi  = ~v.a[19:8];
    dt_r  = v.wr;
    rd_n  = v.wr;
    wr_n  = ~v.wr;
    #1;
    held = v.a;
    chk("R1 latched address", addr_out, held);
    chk("R3 mem read", mem_rd_n, !(!v.wr && !v.io));
    chk("R3 mem write", mem_wr_n, !(v.wr && !v.io));
    chk("R4 io read", io_rd_n, !(!v.wr && v.io));
    chk("R4 io write", io_wr_n, !(v.wr && v.io));
    chk(v.part ? "R7 rom select" : "R5 rom select", rom_cs_n, v.sel != 2'd1);
    chk(v.part ? "R7 ram select" : "R6 ram select", ram_cs_n, v.sel != 2'd2);
    chk("R10 one select at most", {1'b0, rom_cs_n} + {1'b0, ram_cs_n} >= 2'd1, 1'b1);
    chk("R8 buffer direction", buf_dir, v.wr);
    chk("R9 buffer on", buf_en_n, 1'b0);
    @(negedge clk);
    rd_n = 1'b1;
    wr_n = 1'b1;
    #1;
    chk("R1 address held", addr_out, held);
    check_idle("idle phase");
  endtask

  initial begin
    #12;
    chk("R2 reset address", addr_out, 20'h0);
    check_idle("reset");
    @(negedge clk);
    ale = 1'b1; ad_in = 8'h55; a_hi = 12'hAAA;
    @(negedge clk);
    #1;
    chk("R2 reset holds address", addr_out, 20'h0);
    ale = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) transfer(VEC[i]);

    // R7: same latched address, mode flip changes the region at once
    transfer('{20'h02000, 1'b0, 1'b0, 1'b0, 2'd0});
    @(negedge clk);
    partial_mode = 1'b1;
    rd_n = 1'b0;
    #1;
    chk("R7 mode flip selects rom", rom_cs_n, 1'b0);
    chk("R7 mode flip no ram", ram_cs_n, 1'b1);
    @(negedge clk);
    rd_n = 1'b1;
    dt_r = 1'b1;
    #1;
    chk("R8 direction while idle", buf_dir, 1'b1);
    check_idle("after flip");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule